// File: doc/BRIEF.md
# Accumulator ALU with Fused Shifter

This block is the arithmetic and logic datapath of a signal-processing core. It holds two 40-bit accumulators, A and B, each made of an 8-bit guard field above a 32-bit body, which is split into a high and a low 16-bit half. Each cycle one operation is applied. Loads, adds, subtracts, bitwise logic, accumulator-to-accumulator adds and signed minimum or maximum selection are all supported. The 40-bit result always passes through a saturating barrel shifter before it is written back. The shifted value is written into the selected accumulator at the next clock edge. In the same cycle, one 16-bit half of it appears on a store-data output, so a shift-and-store needs no extra cycle.

An exponent encoder watches the selected accumulator. It reports how far that value can be normalised, so software can treat accumulator contents as the mantissa of a floating-point style number. Instruction decoding, the multiplier and memory addressing are outside this block. The caller presents an already decoded opcode, the operand, a signed shift amount and the select inputs.

Top module: `acc_shift_alu`

## Requirements
- R1: After a cycle with rst_n low, both accumulators read zero and exp_o reads 31.
- R2: Opcodes 1 (load operand), 2 (selected plus operand) and 3 (selected minus operand) write the selected accumulator (acc_sel_i 0 = A, 1 = B) with 40-bit wrap-around. The other accumulator is unchanged.
- R3: Opcodes 4 (AND), 5 (OR) and 6 (XOR) combine bits 31:0 of the selected accumulator and the operand, and force bits 39:32 of the result to zero before the shift.
- R4: shamt_i is a signed 6-bit value applied to every result before write-back. A positive value shifts left, filling with zeros. A negative value shifts right arithmetically by its magnitude.
- R5: If a left shift would change the value's 40-bit signed meaning, the result saturates to 0x7F_FFFF_FFFF for a non-negative input or 0x80_0000_0000 for a negative input.
- R6: store_data_o is combinational in the current cycle. It carries bits 31:16 of the shifted result when store_hi_i is 1, and bits 15:0 otherwise. Opcode 10 (store) shifts the selected accumulator out to this port and writes no accumulator.
- R7: exp_o is a signed 6-bit value. It equals the number of bits below bit 39 of the selected accumulator that match bit 39 before the first one that differs, minus 8. An all-zero or all-one accumulator gives 31.
- R8: Opcodes 8 (MIN) and 9 (MAX) compare A and B as signed 40-bit numbers. They write the smaller (MIN) or larger (MAX) of the two, shifted, into the selected accumulator.
- R9: Opcode 0 and opcodes 11 to 15 leave both accumulators unchanged.
- R10: Opcode 7 writes the selected accumulator plus the other accumulator, shifted, into the selected accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Decoded operation code |
| operand_i | input | 40 | Operand bus |
| shamt_i | input | 6 | Signed shift amount |
| acc_sel_i | input | 1 | Accumulator select (0 = A, 1 = B) |
| store_hi_i | input | 1 | Store half select (1 = high, 0 = low) |
| store_data_o | output | 16 | Selected half of the shifted result |
| exp_o | output | 6 | Signed normalisation count of the selected accumulator |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |

## Verification
The bench drives an add that carries out of bit 39. A design that saturated the add, or that kept a forty-first bit, would leave the wrong value in the accumulator.

It feeds the logic operations operands whose guard bits are set. It also drives left shifts that overflow in both signs, and the extreme shift amounts +31 and -32. A shifter that truncated instead of saturating, or that shifted right logically instead of arithmetically, would show a wrong sign or wrong magnitude.

The exponent is checked on zero, on all ones, on values just at and beyond the guard boundary, and on negative values. The minimum and maximum operations are checked with mixed signs, where an unsigned compare picks the other operand. Reserved opcodes are checked to change nothing.

// File: rtl/acc_alu_pkg.sv
// Package: shared widths and the operation encoding for the accumulator ALU.
// Assumes the opcode values are fixed by the instruction decoder upstream.
package acc_alu_pkg;
    parameter int ACC_W   = 40;
    parameter int GUARD_W = 8;
    parameter int HALF_W  = 16;
    parameter int SH_W    = 6;
    parameter int EXP_W   = 6;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_XOR   = 4'd6,
        OP_ADDX  = 4'd7,
        OP_MIN   = 4'd8,
        OP_MAX   = 4'd9,
        OP_STORE = 4'd10
    } alu_op_e;
endpackage

// File: rtl/alu_core.sv
// Module: alu_core
// Combinational arithmetic/logic stage. It produces the unshifted result and
// a write-enable for the destination accumulator.
// Assumes src is the selected accumulator and oth is the other one.
module alu_core #(
    parameter int W       = 40,
    parameter int GUARD_W = 8
) (
    input  logic [3:0]   op,
    input  logic         sel_b,
    input  logic [W-1:0] src,
    input  logic [W-1:0] oth,
    input  logic [W-1:0] operand,
    output logic [W-1:0] res,
    output logic         wr_en
);
    import acc_alu_pkg::*;

    localparam int BODY_W = W - GUARD_W;

    logic [W-1:0]      acc_a_v;
    logic [W-1:0]      acc_b_v;
    logic              a_less_b;
    logic [BODY_W-1:0] body_and;
    logic [BODY_W-1:0] body_or;
    logic [BODY_W-1:0] body_xor;

    // Purpose: recover A and B order for the symmetric compare.
    always_comb begin
        acc_a_v  = sel_b ? oth : src;
        acc_b_v  = sel_b ? src : oth;
        a_less_b = $signed(acc_a_v) < $signed(acc_b_v);
        body_and = src[BODY_W-1:0] & operand[BODY_W-1:0];
        body_or  = src[BODY_W-1:0] | operand[BODY_W-1:0];
        body_xor = src[BODY_W-1:0] ^ operand[BODY_W-1:0];
    end

    // Purpose: select the operation result and whether it is written back.
    always_comb begin
        res   = src;
        wr_en = 1'b1;
        case (op)
            OP_LOAD:  res = operand;
            OP_ADD:   res = src + operand;
            OP_SUB:   res = src - operand;
            OP_AND:   res = {{GUARD_W{1'b0}}, body_and};
            OP_OR:    res = {{GUARD_W{1'b0}}, body_or};
            OP_XOR:   res = {{GUARD_W{1'b0}}, body_xor};
            OP_ADDX:  res = src + oth;
            OP_MIN:   res = a_less_b ? acc_a_v : acc_b_v;
            OP_MAX:   res = a_less_b ? acc_b_v : acc_a_v;
            OP_STORE: begin
                res   = src;
                wr_en = 1'b0;
            end
            default:  wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/sat_shifter.sv
// Module: sat_shifter
// Combinational barrel shifter driven by a signed amount. Left shifts
// saturate on signed overflow; right shifts are arithmetic.
// Assumes the magnitude of a left shift is below W.
module sat_shifter #(
    parameter int W    = 40,
    parameter int SH_W = 6
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] shamt,
    output logic [W-1:0]    dout
);
    localparam int XW = 2 * W;

    logic [SH_W-1:0] mag;
    logic [XW-1:0]   wide;
    logic [W:0]      top_bits;
    logic            ovf;
    logic [W-1:0]    sat_val;

    // Purpose: magnitude of the signed shift amount.
    always_comb begin
        mag = shamt[SH_W-1] ? (~shamt + 1'b1) : shamt;
    end

    // Purpose: widen, shift left and detect loss of sign information.
    always_comb begin
        wide     = {{W{din[W-1]}}, din} << mag;
        top_bits = wide[XW-1:W-1];
        ovf      = !((&top_bits) || !(|top_bits));
        sat_val  = din[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end

    // Purpose: pick the left, right or saturated form.
    always_comb begin
        if (shamt[SH_W-1]) begin
            dout = W'($signed(din) >>> mag);
        end else if (ovf) begin
            dout = sat_val;
        end else begin
            dout = wide[W-1:0];
        end
    end
endmodule

// File: rtl/exp_encoder.sv
// Module: exp_encoder
// Counts the redundant sign bits of a W-bit value and subtracts the guard
// width, giving a signed normalisation count.
// Assumes the count always fits in EXP_W bits as a signed value.
module exp_encoder #(
    parameter int W       = 40,
    parameter int GUARD_W = 8,
    parameter int EXP_W   = 6
) (
    input  logic [W-1:0]     din,
    output logic [EXP_W-1:0] exp_val
);
    int  run;
    logic stop;

    // Purpose: walk down from below the sign bit until a bit differs.
    always_comb begin
        run  = 0;
        stop = 1'b0;
        for (int i = W - 2; i >= 0; i--) begin
            if (!stop) begin
                if (din[i] == din[W-1]) begin
                    run = run + 1;
                end else begin
                    stop = 1'b1;
                end
            end
        end
        exp_val = EXP_W'(run - GUARD_W);
    end
endmodule

// File: rtl/acc_shift_alu.sv
// Module: acc_shift_alu
// Two-accumulator ALU with a fused saturating shifter, a store-data port and
// an exponent encoder. A result is written at the clock edge after its
// inputs are presented; the store port and the exponent are combinational.
// Assumes inputs are stable around the rising edge; reset is synchronous, active low.
module acc_shift_alu #(
    parameter int ACC_W   = acc_alu_pkg::ACC_W,
    parameter int GUARD_W = acc_alu_pkg::GUARD_W,
    parameter int HALF_W  = acc_alu_pkg::HALF_W,
    parameter int SH_W    = acc_alu_pkg::SH_W,
    parameter int EXP_W   = acc_alu_pkg::EXP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [ACC_W-1:0]  operand_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic              acc_sel_i,
    input  logic              store_hi_i,
    output logic [HALF_W-1:0] store_data_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [ACC_W-1:0]  acc_a_o,
    output logic [ACC_W-1:0]  acc_b_o
);
    import acc_alu_pkg::*;

    localparam int N_ACC = 2;

    logic [ACC_W-1:0] acc_q [N_ACC];
    logic [ACC_W-1:0] src_v;
    logic [ACC_W-1:0] oth_v;
    logic [ACC_W-1:0] alu_res;
    logic [ACC_W-1:0] shifted;
    logic             wr_en;

    // Purpose: route the selected and the other accumulator to the ALU.
    always_comb begin
        src_v = acc_sel_i ? acc_q[1] : acc_q[0];
        oth_v = acc_sel_i ? acc_q[0] : acc_q[1];
    end

    alu_core #(.W(ACC_W), .GUARD_W(GUARD_W)) alu_i (
        .op      (op_i),
        .sel_b   (acc_sel_i),
        .src     (src_v),
        .oth     (oth_v),
        .operand (operand_i),
        .res     (alu_res),
        .wr_en   (wr_en)
    );

    sat_shifter #(.W(ACC_W), .SH_W(SH_W)) shf_i (
        .din   (alu_res),
        .shamt (shamt_i),
        .dout  (shifted)
    );

    // Purpose: pick the store half of the shifted result.
    always_comb begin
        store_data_o = store_hi_i ? shifted[2*HALF_W-1:HALF_W] : shifted[HALF_W-1:0];
    end

    // Purpose: one write-enabled register per accumulator.
    for (genvar g = 0; g < N_ACC; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q[g] <= '0;
            end else if (wr_en && (acc_sel_i == 1'(g))) begin
                acc_q[g] <= shifted;
            end
        end
    end

    exp_encoder #(.W(ACC_W), .GUARD_W(GUARD_W), .EXP_W(EXP_W)) exp_i (
        .din     (src_v),
        .exp_val (exp_o)
    );

    assign acc_a_o = acc_q[0];
    assign acc_b_o = acc_q[1];

    // Assertions next to the datapath they guard.
    p_reserved_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 || op_i > 4'd10) |=> ($stable(acc_a_o) && $stable(acc_b_o)));

    p_other_keep_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sel_i |=> $stable(acc_a_o));

    p_other_keep_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_sel_i |=> $stable(acc_b_o));

    p_store_writes_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd10) |=> ($stable(acc_a_o) && $stable(acc_b_o)));

    p_guard_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd4 && op_i <= 4'd6 && !acc_sel_i && shamt_i[SH_W-1])
        |=> (acc_a_o[ACC_W-1:ACC_W-GUARD_W] == '0));

    p_sat_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1 && !acc_sel_i && !shamt_i[SH_W-1])
        |=> (acc_a_o[ACC_W-1] == $past(operand_i[ACC_W-1])));

    p_max_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd9 && !acc_sel_i && shamt_i == '0)
        |=> ($signed(acc_a_o) >= $signed(acc_b_o)));

    p_store_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd10 && store_hi_i && shamt_i == '0)
        |-> (store_data_o == src_v[2*HALF_W-1:HALF_W]));

    p_exp_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(exp_o) >= -GUARD_W) && ($signed(exp_o) <= ACC_W - 1 - GUARD_W));
endmodule

// File: tb/acc_shift_alu_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task models each operation and queues the
// expected accumulator state; the monitor compares it after the clock edge.
module acc_shift_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [39:0] operand_i = '0;
    logic [5:0]  shamt_i = '0;
    logic        acc_sel_i = 1'b0;
    logic        store_hi_i = 1'b0;
    logic [15:0] store_data_o;
    logic [5:0]  exp_o;
    logic [39:0] acc_a_o;
    logic [39:0] acc_b_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [39:0] a;
        logic [39:0] b;
        logic [5:0]  e;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    logic [39:0] ma = '0;
    logic [39:0] mb = '0;

    always #2 clk = ~clk;

    acc_shift_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .operand_i(operand_i),
        .shamt_i(shamt_i), .acc_sel_i(acc_sel_i), .store_hi_i(store_hi_i),
        .store_data_o(store_data_o), .exp_o(exp_o),
        .acc_a_o(acc_a_o), .acc_b_o(acc_b_o)
    );

    function automatic logic [39:0] m_shift(input logic [39:0] v, input logic [5:0] n);
        logic signed [79:0] ext;
        int k;
        k = $signed(n);
        if (k < 0) return 40'($signed(v) >>> (-k));
        ext = {{40{v[39]}}, v};
        ext = ext <<< k;
        if (ext[79:39] == '0 || ext[79:39] == '1) return ext[39:0];
        return v[39] ? 40'h80_0000_0000 : 40'h7F_FFFF_FFFF;
    endfunction

    function automatic logic [5:0] m_exp(input logic [39:0] v);
        int c = 0;
        for (int i = 38; i >= 0; i--) begin
            if (v[i] != v[39]) break;
            c++;
        end
        return 6'(c - 8);
    endfunction

    task automatic check(input string req, input string what, input logic [39:0] act, input logic [39:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
        end
    endtask

    // Driver: apply one operation, model it, check the store port, queue the state.
    task automatic do_op(input string req, input logic [3:0] op, input logic [39:0] opnd,
                         input int sh, input logic sel, input logic hi);
        logic [39:0] src, oth, r, r2;
        logic wr;
        exp_item_t it;
        @(negedge clk);
        op_i = op; operand_i = opnd; shamt_i = 6'(sh); acc_sel_i = sel; store_hi_i = hi;
        src = sel ? mb : ma;
        oth = sel ? ma : mb;
        wr = (op >= 4'd1 && op <= 4'd9);
        case (op)
            4'd1: r = opnd;
            4'd2: r = src + opnd;
            4'd3: r = src - opnd;
            4'd4: r = {8'h00, src[31:0] & opnd[31:0]};
            4'd5: r = {8'h00, src[31:0] | opnd[31:0]};
            4'd6: r = {8'h00, src[31:0] ^ opnd[31:0]};
            4'd7: r = src + oth;
            4'd8: r = ($signed(ma) < $signed(mb)) ? ma : mb;
            4'd9: r = ($signed(ma) < $signed(mb)) ? mb : ma;
            default: r = src;
        endcase
        r2 = m_shift(r, 6'(sh));
        #1;
        if (op >= 4'd1 && op <= 4'd10)
            check({req, "/R6"}, "store_data", 40'(store_data_o), 40'(hi ? r2[31:16] : r2[15:0]));
        if (wr) begin
            if (sel) mb = r2; else ma = r2;
        end
        it.a = ma; it.b = mb; it.e = m_exp(sel ? mb : ma); it.tag = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare the queued state after each clock edge.
    initial begin
        exp_item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(it.tag, "acc_a", acc_a_o, it.a);
                check(it.tag, "acc_b", acc_b_o, it.b);
                check({it.tag, "/R7"}, "exp", 40'(exp_o), 40'(it.e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        op_i = 4'd5; operand_i = '1; shamt_i = 6'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        op_i = 4'd0;
        rst_n = 1'b1;
        #1;
        check("R1", "acc_a reset", acc_a_o, '0);
        check("R1", "acc_b reset", acc_b_o, '0);
        check("R1", "exp reset", 40'(exp_o), 40'd31);

        do_op("R2", 4'd1, 40'h12_3456_789A, 0, 1'b0, 1'b0);
        do_op("R6", 4'd10, 40'h0, 0, 1'b0, 1'b1);
        do_op("R6", 4'd10, 40'h0, 0, 1'b0, 1'b0);
        do_op("R2", 4'd1, 40'h7F_FFFF_FFFF, 0, 1'b1, 1'b1);
        do_op("R2", 4'd2, 40'h1, 0, 1'b1, 1'b0);
        do_op("R2", 4'd3, 40'h00_0000_1000, 0, 1'b0, 1'b1);
        do_op("R2", 4'd3, 40'h80_0000_0000, 0, 1'b1, 1'b0);
        do_op("R3", 4'd1, 40'hFF_F0F0_F0F0, 0, 1'b0, 1'b0);
        do_op("R3", 4'd4, 40'hAB_FF00_FF00, 0, 1'b0, 1'b1);
        do_op("R3", 4'd5, 40'hCD_0000_000F, 0, 1'b0, 1'b0);
        do_op("R3", 4'd6, 40'hEE_FFFF_FFFF, -1, 1'b0, 1'b1);
        do_op("R4", 4'd1, 40'h00_0000_1234, 4, 1'b1, 1'b0);
        do_op("R4", 4'd1, 40'hF0_0000_0000, -4, 1'b1, 1'b1);
        do_op("R4", 4'd1, 40'hFF_FFFF_FFFF, -32, 1'b0, 1'b0);
        do_op("R4", 4'd10, 40'h0, 8, 1'b1, 1'b1);
        do_op("R5", 4'd1, 40'h00_4000_0000, 9, 1'b0, 1'b1);
        do_op("R5", 4'd1, 40'hF0_0000_0001, 31, 1'b1, 1'b0);
        do_op("R5", 4'd1, 40'h00_0000_0001, 31, 1'b0, 1'b1);
        do_op("R7", 4'd1, 40'h00_0000_0000, 0, 1'b0, 1'b0);
        do_op("R7", 4'd1, 40'hFF_FFFF_FFFF, 0, 1'b1, 1'b0);
        do_op("R7", 4'd1, 40'h00_8000_0000, 0, 1'b0, 1'b0);
        do_op("R7", 4'd1, 40'h00_4000_0000, 0, 1'b1, 1'b0);
        do_op("R7", 4'd1, 40'hFF_8000_0000, 0, 1'b1, 1'b0);
        do_op("R8", 4'd1, 40'hFF_FFFF_FFF0, 0, 1'b0, 1'b0);
        do_op("R8", 4'd1, 40'h00_0000_0005, 0, 1'b1, 1'b0);
        do_op("R8", 4'd9, 40'h0, 0, 1'b0, 1'b0);
        do_op("R8", 4'd1, 40'hFF_FFFF_FFF0, 0, 1'b0, 1'b0);
        do_op("R8", 4'd8, 40'h0, 0, 1'b1, 1'b0);
        do_op("R10", 4'd1, 40'h00_0000_0100, 0, 1'b0, 1'b0);
        do_op("R10", 4'd7, 40'h0, 1, 1'b1, 1'b0);
        do_op("R9", 4'd0, 40'hFF_FFFF_FFFF, 5, 1'b0, 1'b1);
        do_op("R9", 4'd15, 40'hFF_FFFF_FFFF, 5, 1'b1, 1'b1);
        do_op("R9", 4'd11, 40'h12_0000_0000, -3, 1'b0, 1'b0);

        @(negedge clk);
        op_i = 4'd0;
        repeat (3) @(posedge clk);
        #1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule